// File: doc/BRIEF.md
# Event-Select Performance Counter

This block is one performance-monitoring counter paired with its event-select control register. Each clock it looks at a bus of per-cycle event lines, a halted indication and the current privilege level, and increments a wide counter when the programmed event is present, counting is switched on, and the privilege level is one the select register allows. Both registers are reached through a simple write port and a registered read port. Reads always return the full counter width.

The usual use is a periodic watchdog. Software loads the two's-complement negative of the wanted period. It can do this with a full-width write, or with a 32-bit write whose bit 31 is copied into every higher bit. The counter then counts up through all-ones to zero. On that wrap it raises a one-cycle interrupt request if the select register allows interrupts. While the top counter bit is still set, the period has not yet run out.

Top module: `evsel_perf_counter`

## Requirements
- R1: The select register keeps the event code in bits 7:0, user-mode counting enable in bit 16, kernel-mode counting enable in bit 17, the overflow interrupt enable in bit 20 and the counter enable in bit 22. A read with `rd_pick_ctr` low returns these bits, and every other bit reads as zero.
- R2: The counter increments by one on a clock edge only if all of these hold: bit 22 is set, the selected event source is high, and either `priv_kernel` is 1 with bit 17 set or `priv_kernel` is 0 with bit 16 set.
- R3: An event code below EVT_N selects `ev_bus[code]`. The code RUN_CODE (default 0x76) counts only cycles where `cpu_halted` is low. Any other code never counts.
- R4: A write with `wr_pick_ctr`=1 and `wr_full`=1 loads all CTR_W bits of `wr_data` into the counter.
- R5: A write with `wr_pick_ctr`=1 and `wr_full`=0 loads `wr_data[31:0]` into the low 32 bits and copies bit 31 into every higher counter bit. The upper bits of `wr_data` are ignored.
- R6: An increment from all-ones wraps the counter to zero. After the wrap the top bit is clear, and counting continues from zero.
- R7: `ovf_irq` is high for exactly the one cycle after the clock edge that wraps the counter, and only if bit 20 was set at that edge.
- R8: A counter write on the same edge as an increment takes priority. The counter takes the written value, and no interrupt is raised even if the counter was all-ones.
- R9: Writing zero to the select register stops counting from the next edge onward. The edge that performs the write still uses the old setting.
- R10: `rd_data` is registered. It shows the register chosen by `rd_pick_ctr` as it stood after the previous edge, one cycle after the choice.
- R11: After reset, the counter, the select register, `rd_data` and `ovf_irq` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_pick_ctr | input | 1 | Write target: 1 counter, 0 select register |
| wr_full | input | 1 | Counter write mode: 1 full width, 0 32-bit with sign extension |
| wr_data | input | CTR_W | Write data; the select register takes bits 31:0 |
| rd_pick_ctr | input | 1 | Read source: 1 counter, 0 select register |
| rd_data | output | CTR_W | Registered read data |
| ev_bus | input | EVT_N | Per-cycle event lines |
| cpu_halted | input | 1 | High on cycles where the processor is halted |
| priv_kernel | input | 1 | 1 when running in kernel mode, 0 in user mode |
| ovf_irq | output | 1 | One-cycle overflow interrupt request |

## Verification
The hardest case to reach from the ports is a counter write that lands on the very edge where an all-ones counter would otherwise wrap. To hit it, the bench preloads -1 with the interrupt enabled. It then releases the halted line and issues the write in the same cycle, so exactly one edge sees both the increment and the write. Its interrupt counter must stay at zero. Both wrap routes are also driven to the exact edge: a full-width preload of -3 and a 32-bit preload of -2. In each case `ovf_irq` is sampled in the cycles before, during and after the wrap.

// File: rtl/pmc_pkg.sv
`timescale 1ns/1ps
package pmc_pkg;
  localparam int SEL_W    = 32;
  localparam int CODE_W   = 8;
  localparam int B_USR    = 16;
  localparam int B_OS     = 17;
  localparam int B_INT    = 20;
  localparam int B_EN     = 22;
  localparam int CODE_SPAN = 1 << CODE_W;

  typedef struct packed {
    logic              en;
    logic              irq_en;
    logic              os;
    logic              usr;
    logic [CODE_W-1:0] code;
  } evsel_t;

  function automatic logic [SEL_W-1:0] sel_to_word(evsel_t s);
    logic [SEL_W-1:0] w;
    w = '0;
    w[CODE_W-1:0] = s.code;
    w[B_USR]      = s.usr;
    w[B_OS]       = s.os;
    w[B_INT]      = s.irq_en;
    w[B_EN]       = s.en;
    return w;
  endfunction

  function automatic evsel_t word_to_sel(logic [SEL_W-1:0] w);
    evsel_t s;
    s.code   = w[CODE_W-1:0];
    s.usr    = w[B_USR];
    s.os     = w[B_OS];
    s.irq_en = w[B_INT];
    s.en     = w[B_EN];
    return s;
  endfunction
endpackage

// File: rtl/pmc_evsel_reg.sv
`timescale 1ns/1ps
module pmc_evsel_reg
  import pmc_pkg::*;
(
  input  logic             clk,
  input  logic             rst,
  input  logic             we,
  input  logic [SEL_W-1:0] wdata,
  output evsel_t           sel_q
);
  always_ff @(posedge clk) begin
    if (rst)     sel_q <= '0;
    else if (we) sel_q <= word_to_sel(wdata);
  end
endmodule

// File: rtl/pmc_event_gate.sv
`timescale 1ns/1ps
module pmc_event_gate
  import pmc_pkg::*;
#(
  parameter int                EVT_N    = 16,
  parameter logic [CODE_W-1:0] RUN_CODE = 8'h76
) (
  input  evsel_t           sel,
  input  logic [EVT_N-1:0] ev_bus,
  input  logic             halted,
  input  logic             priv_kernel,
  output logic             hit
);
  logic [CODE_SPAN-1:0] ev_pad;
  logic                 src;
  logic                 priv_ok;

  // Widen the event bus to the full code space so any code indexes safely.
  for (genvar i = 0; i < CODE_SPAN; i++) begin : g_pad
    if (i < EVT_N) begin : g_live
      assign ev_pad[i] = ev_bus[i];
    end else begin : g_dead
      assign ev_pad[i] = 1'b0;
    end
  end

  always_comb begin
    if (sel.code == RUN_CODE) src = ~halted;
    else                      src = ev_pad[sel.code];
    priv_ok = (priv_kernel & sel.os) | (~priv_kernel & sel.usr);
    hit     = sel.en & priv_ok & src;
  end
endmodule

// File: rtl/pmc_count_reg.sv
`timescale 1ns/1ps
module pmc_count_reg #(
  parameter int CTR_W = 48
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             inc,
  input  logic             irq_en,
  input  logic             wr_en,
  input  logic             wr_full,
  input  logic [CTR_W-1:0] wr_data,
  output logic [CTR_W-1:0] ctr_q,
  output logic             irq_q
);
  localparam int EXT_W = CTR_W - 32;

  logic [CTR_W-1:0] narrow_val;
  logic [CTR_W-1:0] load_val;
  logic             wrap;

  assign narrow_val = {{EXT_W{wr_data[31]}}, wr_data[31:0]};
  assign load_val   = wr_full ? wr_data : narrow_val;
  assign wrap       = inc & (&ctr_q) & ~wr_en;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctr_q <= '0;
      irq_q <= 1'b0;
    end else begin
      if (wr_en)    ctr_q <= load_val;
      else if (inc) ctr_q <= ctr_q + CTR_W'(1);
      irq_q <= wrap & irq_en;
    end
  end
endmodule

// File: rtl/evsel_perf_counter.sv
`timescale 1ns/1ps
module evsel_perf_counter
  import pmc_pkg::*;
#(
  parameter int                CTR_W    = 48,
  parameter int                EVT_N    = 16,
  parameter logic [CODE_W-1:0] RUN_CODE = 8'h76
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_pick_ctr,
  input  logic             wr_full,
  input  logic [CTR_W-1:0] wr_data,
  input  logic             rd_pick_ctr,
  output logic [CTR_W-1:0] rd_data,
  input  logic [EVT_N-1:0] ev_bus,
  input  logic             cpu_halted,
  input  logic             priv_kernel,
  output logic             ovf_irq
);
  localparam int PAD_W = CTR_W - SEL_W;

  evsel_t           sel_q;
  logic             hit;
  logic             ctr_we;
  logic             sel_we;
  logic [CTR_W-1:0] ctr_q;

  assign ctr_we = wr_en & wr_pick_ctr;
  assign sel_we = wr_en & ~wr_pick_ctr;

  pmc_evsel_reg u_sel (
    .clk   (clk),
    .rst   (rst),
    .we    (sel_we),
    .wdata (wr_data[SEL_W-1:0]),
    .sel_q (sel_q)
  );

  pmc_event_gate #(.EVT_N(EVT_N), .RUN_CODE(RUN_CODE)) u_gate (
    .sel         (sel_q),
    .ev_bus      (ev_bus),
    .halted      (cpu_halted),
    .priv_kernel (priv_kernel),
    .hit         (hit)
  );

  pmc_count_reg #(.CTR_W(CTR_W)) u_cnt (
    .clk     (clk),
    .rst     (rst),
    .inc     (hit),
    .irq_en  (sel_q.irq_en),
    .wr_en   (ctr_we),
    .wr_full (wr_full),
    .wr_data (wr_data),
    .ctr_q   (ctr_q),
    .irq_q   (ovf_irq)
  );

  always_ff @(posedge clk) begin
    if (rst)              rd_data <= '0;
    else if (rd_pick_ctr) rd_data <= ctr_q;
    else                  rd_data <= {{PAD_W{1'b0}}, sel_to_word(sel_q)};
  end
endmodule

// File: rtl/evsel_perf_counter_chk.sv
`timescale 1ns/1ps
module evsel_perf_counter_chk #(
  parameter int CTR_W = 48
) (
  input logic             clk,
  input logic             rst,
  input logic [CTR_W-1:0] ctr,
  input logic             irq,
  input logic             sel_en,
  input logic             sel_irq_en,
  input logic             wr_en,
  input logic             wr_pick_ctr,
  input logic             wr_full,
  input logic [CTR_W-1:0] wr_data
);
  logic ctr_we;
  assign ctr_we = wr_en & wr_pick_ctr;

  p_irq_single_r7: assert property (@(posedge clk) disable iff (rst)
    irq |=> !irq);

  p_irq_at_zero_r6: assert property (@(posedge clk) disable iff (rst)
    irq |-> (ctr == '0));

  p_irq_gated_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> $past(sel_irq_en));

  p_hold_disabled_r2: assert property (@(posedge clk) disable iff (rst)
    (!sel_en && !ctr_we) |=> (ctr == $past(ctr)));

  p_step_one_r6: assert property (@(posedge clk) disable iff (rst)
    !ctr_we |=> ((ctr == $past(ctr)) || (ctr == $past(ctr) + CTR_W'(1))));

  p_full_write_r8: assert property (@(posedge clk) disable iff (rst)
    (ctr_we && wr_full) |=> (ctr == $past(wr_data)));

  p_narrow_write_r5: assert property (@(posedge clk) disable iff (rst)
    (ctr_we && !wr_full) |=>
      ((ctr[31:0] == $past(wr_data[31:0])) &&
       (ctr[CTR_W-1] == $past(wr_data[31]))));

  p_write_no_irq_r8: assert property (@(posedge clk) disable iff (rst)
    ctr_we |=> !irq);
endmodule

bind evsel_perf_counter evsel_perf_counter_chk #(.CTR_W(CTR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ctr         (ctr_q),
  .irq         (ovf_irq),
  .sel_en      (sel_q.en),
  .sel_irq_en  (sel_q.irq_en),
  .wr_en       (wr_en),
  .wr_pick_ctr (wr_pick_ctr),
  .wr_full     (wr_full),
  .wr_data     (wr_data)
);

// File: tb/test_evsel_perf_counter.sv
`timescale 1ns/1ps
module test_evsel_perf_counter;
  localparam int CTR_W = 48;
  localparam int EVT_N = 16;
  localparam logic [CTR_W-1:0] ALL1 = {CTR_W{1'b1}};

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             wr_en = 1'b0;
  logic             wr_pick_ctr = 1'b0;
  logic             wr_full = 1'b0;
  logic [CTR_W-1:0] wr_data = '0;
  logic             rd_pick_ctr = 1'b0;
  logic [CTR_W-1:0] rd_data;
  logic [EVT_N-1:0] ev_bus = '0;
  logic             cpu_halted = 1'b1;
  logic             priv_kernel = 1'b0;
  logic             ovf_irq;

  int total = 0;
  int bad = 0;
  int pulses = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  evsel_perf_counter #(.CTR_W(CTR_W), .EVT_N(EVT_N)) i_evsel_perf_counter (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_pick_ctr(wr_pick_ctr),
    .wr_full(wr_full), .wr_data(wr_data), .rd_pick_ctr(rd_pick_ctr),
    .rd_data(rd_data), .ev_bus(ev_bus), .cpu_halted(cpu_halted),
    .priv_kernel(priv_kernel), .ovf_irq(ovf_irq)
  );

  always @(negedge clk) if (!rst && ovf_irq) pulses++;

  typedef struct packed {
    logic [31:0] sel;
    logic [15:0] ev;
    logic        hlt;
    logic        kern;
    logic [7:0]  n;
    logic [7:0]  exp;
  } vec_t;

  // sel bits: 22 enable, 20 irq enable, 17 kernel, 16 user, 7:0 code
  localparam vec_t VEC [10] = '{
    '{32'h0042_0003, 16'h0008, 1'b1, 1'b1, 8'd5, 8'd5}, // R2 kernel match
    '{32'h0042_0003, 16'h0008, 1'b1, 1'b0, 8'd5, 8'd0}, // R2 user, kernel-only
    '{32'h0041_0003, 16'h0008, 1'b1, 1'b0, 8'd5, 8'd5}, // R2 user match
    '{32'h0043_0003, 16'h0004, 1'b1, 1'b1, 8'd5, 8'd0}, // R3 other line high
    '{32'h0003_0003, 16'h0008, 1'b1, 1'b1, 8'd5, 8'd0}, // R2 enable clear
    '{32'h0043_0076, 16'h0000, 1'b0, 1'b1, 8'd5, 8'd5}, // R3 running cycles
    '{32'h0043_0076, 16'hFFFF, 1'b1, 1'b0, 8'd5, 8'd0}, // R3 halted
    '{32'h0042_0020, 16'hFFFF, 1'b0, 1'b1, 8'd5, 8'd0}, // R3 unmapped code
    '{32'h0043_000F, 16'h8000, 1'b1, 1'b0, 8'd5, 8'd5}, // R3 top line
    '{32'h0000_0000, 16'hFFFF, 1'b0, 1'b1, 8'd5, 8'd0}  // R9 zero select
  };

  task automatic chk(string req, logic [CTR_W-1:0] act, logic [CTR_W-1:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic to_ctr, logic full, logic [CTR_W-1:0] d);
    wr_en = 1'b1; wr_pick_ctr = to_ctr; wr_full = full; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(logic pick_ctr, output logic [CTR_W-1:0] v);
    rd_pick_ctr = pick_ctr;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic quiet();
    ev_bus = '0; cpu_halted = 1'b1;
  endtask

  initial begin
    logic [CTR_W-1:0] v;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    // R11 reset state
    chk("R11 rd_data", rd_data, '0);
    chk("R11 irq", {47'd0, ovf_irq}, '0);
    rd(1'b1, v); chk("R11 counter", v, '0);
    rd(1'b0, v); chk("R11 select", v, '0);

    foreach (VEC[i]) begin
      wr(1'b0, 1'b1, {16'd0, VEC[i].sel});
      wr(1'b1, 1'b1, '0);
      ev_bus = VEC[i].ev; cpu_halted = VEC[i].hlt; priv_kernel = VEC[i].kern;
      repeat (int'(VEC[i].n)) @(negedge clk);
      quiet();
      rd(1'b1, v); chk($sformatf("R2/R3 vector %0d count", i), v, {40'd0, VEC[i].exp});
      rd(1'b0, v); chk($sformatf("R1 vector %0d select", i), v, {16'd0, VEC[i].sel});
    end

    // R1 undefined select bits read zero
    wr(1'b0, 1'b1, 48'h0000_FFFF_FFFF);
    rd(1'b0, v); chk("R1 reserved bits", v, 48'h0000_0053_00FF);

    // R4 full-width load, R10 one-cycle read
    wr(1'b0, 1'b1, '0);
    wr(1'b1, 1'b1, 48'h1234_5678_9ABC);
    rd(1'b1, v); chk("R4 full write", v, 48'h1234_5678_9ABC);
    rd_pick_ctr = 1'b0; #1; chk("R10 read before edge", rd_data, 48'h1234_5678_9ABC);
    @(negedge clk); chk("R10 read after edge", rd_data, '0);

    // R5 sign extension both ways, upper data ignored
    wr(1'b1, 1'b0, 48'h0000_8000_0005);
    rd(1'b1, v); chk("R5 negative narrow", v, 48'hFFFF_8000_0005);
    wr(1'b1, 1'b0, 48'hABCD_7FFF_FFFF);
    rd(1'b1, v); chk("R5 positive narrow", v, 48'h0000_7FFF_FFFF);

    // R6/R7 overflow from a full-width -3 preload
    priv_kernel = 1'b1;
    wr(1'b0, 1'b1, 48'h0053_0076);
    wr(1'b1, 1'b1, ALL1 - 48'd2);
    pulses = 0;
    cpu_halted = 1'b0;
    repeat (2) @(negedge clk);
    chk("R7 no irq before wrap", {47'd0, ovf_irq}, '0);
    @(negedge clk);
    chk("R7 irq on wrap", {47'd0, ovf_irq}, 48'd1);
    @(negedge clk);
    chk("R7 irq one cycle", {47'd0, ovf_irq}, '0);
    @(negedge clk);
    quiet();
    rd(1'b1, v); chk("R6 count after wrap", v, 48'd2);
    chk("R6 top bit clear", {47'd0, v[CTR_W-1]}, '0);
    chk("R7 single pulse", 48'(pulses), 48'd1);

    // R5/R6 watchdog preload through 32-bit write (-2)
    wr(1'b1, 1'b0, 48'h0000_FFFF_FFFE);
    rd(1'b1, v); chk("R5 narrow -2", v, ALL1 - 48'd1);
    pulses = 0;
    cpu_halted = 1'b0;
    @(negedge clk);
    chk("R6 top bit still set", {47'd0, rd_data[CTR_W-1]}, 48'd1);
    @(negedge clk);
    quiet();
    chk("R7 narrow wrap irq", {47'd0, ovf_irq}, 48'd1);
    rd(1'b1, v); chk("R6 narrow wrap zero", v, '0);

    // R7 interrupt enable clear: wrap without request
    wr(1'b0, 1'b1, 48'h0043_0076);
    wr(1'b1, 1'b1, ALL1);
    pulses = 0;
    cpu_halted = 1'b0;
    @(negedge clk);
    quiet();
    rd(1'b1, v); chk("R6 wrap no-int", v, '0);
    chk("R7 no irq when disabled", 48'(pulses), '0);

    // R8 write beats increment, including on the wrap edge
    wr(1'b0, 1'b1, 48'h0053_0076);
    wr(1'b1, 1'b1, ALL1);
    pulses = 0;
    cpu_halted = 1'b0;
    wr(1'b1, 1'b1, 48'h55);
    quiet();
    rd(1'b1, v); chk("R8 write on wrap edge", v, 48'h55);
    repeat (2) @(negedge clk);
    chk("R8 no irq", 48'(pulses), '0);
    cpu_halted = 1'b0;
    repeat (3) @(negedge clk);
    wr(1'b1, 1'b1, 48'h100);
    quiet();
    rd(1'b1, v); chk("R8 write mid-count", v, 48'h100);

    // R9 zero select stops counting after its own edge
    wr(1'b1, 1'b1, '0);
    cpu_halted = 1'b0;
    repeat (4) @(negedge clk);
    wr(1'b0, 1'b1, '0);
    repeat (4) @(negedge clk);
    rd(1'b1, v); chk("R9 stop on zero select", v, 48'd5);
    quiet();

    if (!done) begin
      done = 1'b1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule